// File: doc/BRIEF.md
# CAN Bit Timing Generator

The block divides the peripheral clock into time quanta and frames every bit on the bus into three parts: a one-quantum synchronization segment, a phase segment before the sample point, and a phase segment after it. It pulses a sample strobe on the quantum that closes the first phase segment, and a bit-boundary strobe on the quantum that closes the second. A protocol engine uses the sample strobe to latch the bus level and the boundary strobe to move on to the next bit.

Two parameter sets are supplied. One is for the arbitration (nominal) phase and one is for the fast data phase of bit-rate-switched frames. A select input chooses between them while the block runs. Each set has its own legal ranges and is given as plain values: the prescaler, the two phase segment lengths and the jump width, with no off-by-one encoding. The active set is captured only at a bit boundary. A falling edge on the receive line (recessive to dominant) stretches the first phase segment or trims the second one. The adjustment is bounded by the jump width, and only the first such edge in a bit counts.

Top module: `can_bit_timing`

## Requirements
- R1: After reset the active set is prescaler 1, phase segment one 11, phase segment two 4, jump width 4 (16 quanta per bit). The synchronization quantum closes at the first clock edge after release, so the first sample strobe comes 11 cycles after release and the first boundary strobe 15 cycles after release. config_error_o is 0.
- R2: tq_tick_o pulses once every P clock cycles, where P is the active prescaler, and there are exactly 1+S1+S2 ticks per bit.
- R3: With active set (P, S1, S2) and no resynchronization, consecutive boundary strobes are P*(1+S1+S2) cycles apart. The sample strobe comes P*(1+S1) cycles after the preceding boundary strobe. Every bit has exactly one sample strobe.
- R4: When data_phase_i=0 the nominal inputs are checked against prescaler 1..512, S1 2..256, S2 2..128, jump width 1..128 and 5..385 quanta per bit. The data inputs are then ignored.
- R5: When data_phase_i=1 the data inputs are checked against prescaler 1..32, S1 1..32, S2 1..16, jump width 1..16 and 3..49 quanta per bit. The nominal inputs are then ignored.
- R6: If the selected set is out of range, config_error_o rises one cycle later. While it is high no tick, sample or boundary strobe is produced. When the inputs become legal again the generator restarts with a fresh bit.
- R7: A change to the inputs or to data_phase_i takes effect only at the next boundary strobe. The bit in progress keeps its length.
- R8: rx_i=0 means dominant. A 1-to-0 transition on rx_i while phase segment one is in quantum k (k counted from 0) lengthens that segment by min(k+1, jump width) quanta. This also holds when the transition lands on the segment's last quantum.
- R9: A 1-to-0 transition on rx_i while phase segment two is in quantum k shortens that segment by min(S2-k, jump width) quanta. The segment never ends before the quantum in which the transition occurred.
- R10: A transition during the synchronization quantum has no effect, and only the first transition in a bit adjusts it.
- R11: The sample and boundary strobes only occur together with tq_tick_o and never occur in the same cycle as each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_phase_i | input | 1 | 1 selects the data-phase set, 0 the nominal set |
| nom_presc_i | input | 10 | Nominal prescaler, clocks per quantum |
| nom_seg1_i | input | 9 | Nominal phase segment one, quanta |
| nom_seg2_i | input | 8 | Nominal phase segment two, quanta |
| nom_sjw_i | input | 8 | Nominal jump width, quanta |
| dat_presc_i | input | 6 | Data-phase prescaler |
| dat_seg1_i | input | 6 | Data-phase phase segment one |
| dat_seg2_i | input | 5 | Data-phase phase segment two |
| dat_sjw_i | input | 5 | Data-phase jump width |
| rx_i | input | 1 | Receive line, 1 recessive, 0 dominant |
| tq_tick_o | output | 1 | One-cycle pulse at the end of each quantum |
| sample_o | output | 1 | Pulse on the quantum that ends phase segment one |
| bit_start_o | output | 1 | Pulse on the quantum that ends the bit; the next quantum starts a new bit |
| config_error_o | output | 1 | Selected parameter set is out of range |

## Verification
Two kinds of event can land in the same cycle. A receive-line edge can arrive on the very quantum whose tick would close a segment, and a parameter-set change can coincide with the boundary that captures it. The bench places an edge on the last quantum of phase segment one and expects the sample strobe to move later by the jump width instead of firing. It places an edge on the last quantum of phase segment two and expects the bit to end on time. It also switches to the data set partway through a bit and expects that bit to keep its nominal length while the next bit takes the data length.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  parameter int unsigned NOM_PRESC_W = 10;
  parameter int unsigned NOM_SEG1_W  = 9;
  parameter int unsigned NOM_SEG2_W  = 8;
  parameter int unsigned NOM_SJW_W   = 8;
  parameter int unsigned DAT_PRESC_W = 6;
  parameter int unsigned DAT_SEG1_W  = 6;
  parameter int unsigned DAT_SEG2_W  = 5;
  parameter int unsigned DAT_SJW_W   = 5;

  parameter int unsigned NOM_PRESC_MAX = 512;
  parameter int unsigned NOM_SEG1_MIN  = 2;
  parameter int unsigned NOM_SEG1_MAX  = 256;
  parameter int unsigned NOM_SEG2_MIN  = 2;
  parameter int unsigned NOM_SEG2_MAX  = 128;
  parameter int unsigned NOM_SJW_MAX   = 128;
  parameter int unsigned NOM_Q_MIN     = 5;
  parameter int unsigned NOM_Q_MAX     = 385;

  parameter int unsigned DAT_PRESC_MAX = 32;
  parameter int unsigned DAT_SEG1_MIN  = 1;
  parameter int unsigned DAT_SEG1_MAX  = 32;
  parameter int unsigned DAT_SEG2_MIN  = 1;
  parameter int unsigned DAT_SEG2_MAX  = 16;
  parameter int unsigned DAT_SJW_MAX   = 16;
  parameter int unsigned DAT_Q_MIN     = 3;
  parameter int unsigned DAT_Q_MAX     = 49;

  // segment counter must hold seg1 plus the largest lengthening
  localparam int unsigned CNT_W = NOM_SEG1_W + 1;

  typedef enum logic [1:0] {SEG_SYNC, SEG_PH1, SEG_PH2} seg_e;

  typedef struct packed {
    logic [NOM_PRESC_W-1:0] presc;
    logic [NOM_SEG1_W-1:0]  seg1;
    logic [NOM_SEG2_W-1:0]  seg2;
    logic [NOM_SJW_W-1:0]   sjw;
  } bt_set_t;

  localparam bt_set_t DEF_SET = '{
    presc: NOM_PRESC_W'(1),
    seg1:  NOM_SEG1_W'(11),
    seg2:  NOM_SEG2_W'(4),
    sjw:   NOM_SJW_W'(4)
  };
endpackage

// File: rtl/can_bt_range_chk.sv
module can_bt_range_chk #(
  parameter int unsigned PW     = 10,
  parameter int unsigned S1W    = 9,
  parameter int unsigned S2W    = 8,
  parameter int unsigned JW     = 8,
  parameter int unsigned P_MAX  = 512,
  parameter int unsigned S1_MIN = 2,
  parameter int unsigned S1_MAX = 256,
  parameter int unsigned S2_MIN = 2,
  parameter int unsigned S2_MAX = 128,
  parameter int unsigned J_MAX  = 128,
  parameter int unsigned Q_MIN  = 5,
  parameter int unsigned Q_MAX  = 385
) (
  input  logic [PW-1:0]  presc_i,
  input  logic [S1W-1:0] seg1_i,
  input  logic [S2W-1:0] seg2_i,
  input  logic [JW-1:0]  sjw_i,
  output logic           ok_o
);
  logic [31:0] p, a, b, j, q;

  always_comb begin
    p = 32'(presc_i);
    a = 32'(seg1_i);
    b = 32'(seg2_i);
    j = 32'(sjw_i);
    q = 32'd1 + a + b;
    ok_o = (p >= 32'd1) && (p <= P_MAX)
        && (a >= S1_MIN) && (a <= S1_MAX)
        && (b >= S2_MIN) && (b <= S2_MAX)
        && (j >= 32'd1)  && (j <= J_MAX)
        && (q >= Q_MIN)  && (q <= Q_MAX);
  end
endmodule

// File: rtl/can_bt_presc.sv
module can_bt_presc #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] lim;

  assign lim    = div_i - W'(1);
  assign tick_o = run_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/can_bt_seg_fsm.sv
module can_bt_seg_fsm
  import can_bt_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  run_i,
  input  logic                  tick_i,
  input  logic                  edge_i,
  input  logic [NOM_SEG1_W-1:0] seg1_i,
  input  logic [NOM_SEG2_W-1:0] seg2_i,
  input  logic [NOM_SJW_W-1:0]  sjw_i,
  output logic                  sample_o,
  output logic                  bit_end_o
);
  seg_e             st_q;
  logic [CNT_W-1:0] cnt_q, ext_q, shr_q;
  logic             rs_done_q;

  logic [CNT_W-1:0] s1, s2, sj, ph1, rem2, ext_new, shr_new, ext_eff, shr_eff;
  logic             edge_ok, seg1_last, seg2_last;

  always_comb begin
    s1      = CNT_W'(seg1_i);
    s2      = CNT_W'(seg2_i);
    sj      = CNT_W'(sjw_i);
    ph1     = cnt_q + CNT_W'(1);
    rem2    = s2 - cnt_q;
    ext_new = (ph1 < sj) ? ph1 : sj;
    shr_new = (rem2 < sj) ? rem2 : sj;
    edge_ok = run_i && edge_i && !rs_done_q;
    // an edge in this very cycle already counts toward the segment end
    ext_eff = (edge_ok && st_q == SEG_PH1) ? ext_new : ext_q;
    shr_eff = (edge_ok && st_q == SEG_PH2) ? shr_new : shr_q;
    seg1_last = (cnt_q == s1 + ext_eff - CNT_W'(1));
    seg2_last = ((cnt_q + shr_eff + CNT_W'(1)) >= s2);
    sample_o  = tick_i && (st_q == SEG_PH1) && seg1_last;
    bit_end_o = tick_i && (st_q == SEG_PH2) && seg2_last;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= SEG_SYNC;
      cnt_q     <= '0;
      ext_q     <= '0;
      shr_q     <= '0;
      rs_done_q <= 1'b0;
    end else if (!run_i) begin
      st_q      <= SEG_SYNC;
      cnt_q     <= '0;
      ext_q     <= '0;
      shr_q     <= '0;
      rs_done_q <= 1'b0;
    end else begin
      if (edge_ok && st_q != SEG_SYNC) begin
        rs_done_q <= 1'b1;
        ext_q     <= ext_eff;
        shr_q     <= shr_eff;
      end
      if (tick_i) begin
        unique case (st_q)
          SEG_SYNC: begin
            st_q  <= SEG_PH1;
            cnt_q <= '0;
          end
          SEG_PH1: begin
            if (seg1_last) begin
              st_q  <= SEG_PH2;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          SEG_PH2: begin
            if (seg2_last) begin
              st_q      <= SEG_SYNC;
              cnt_q     <= '0;
              ext_q     <= '0;
              shr_q     <= '0;
              rs_done_q <= 1'b0;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          default: st_q <= SEG_SYNC;
        endcase
      end
    end
  end
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
  import can_bt_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   data_phase_i,
  input  logic [NOM_PRESC_W-1:0] nom_presc_i,
  input  logic [NOM_SEG1_W-1:0]  nom_seg1_i,
  input  logic [NOM_SEG2_W-1:0]  nom_seg2_i,
  input  logic [NOM_SJW_W-1:0]   nom_sjw_i,
  input  logic [DAT_PRESC_W-1:0] dat_presc_i,
  input  logic [DAT_SEG1_W-1:0]  dat_seg1_i,
  input  logic [DAT_SEG2_W-1:0]  dat_seg2_i,
  input  logic [DAT_SJW_W-1:0]   dat_sjw_i,
  input  logic                   rx_i,
  output logic                   tq_tick_o,
  output logic                   sample_o,
  output logic                   bit_start_o,
  output logic                   config_error_o
);
  bt_set_t act_q, sel_set;
  logic    nom_ok, dat_ok, err_q, err_d, rx_q, fall, run, tick, bit_end;

  can_bt_range_chk #(
    .PW(NOM_PRESC_W), .S1W(NOM_SEG1_W), .S2W(NOM_SEG2_W), .JW(NOM_SJW_W),
    .P_MAX(NOM_PRESC_MAX), .S1_MIN(NOM_SEG1_MIN), .S1_MAX(NOM_SEG1_MAX),
    .S2_MIN(NOM_SEG2_MIN), .S2_MAX(NOM_SEG2_MAX), .J_MAX(NOM_SJW_MAX),
    .Q_MIN(NOM_Q_MIN), .Q_MAX(NOM_Q_MAX)
  ) u_nom_chk (
    .presc_i(nom_presc_i), .seg1_i(nom_seg1_i), .seg2_i(nom_seg2_i),
    .sjw_i(nom_sjw_i), .ok_o(nom_ok)
  );

  can_bt_range_chk #(
    .PW(DAT_PRESC_W), .S1W(DAT_SEG1_W), .S2W(DAT_SEG2_W), .JW(DAT_SJW_W),
    .P_MAX(DAT_PRESC_MAX), .S1_MIN(DAT_SEG1_MIN), .S1_MAX(DAT_SEG1_MAX),
    .S2_MIN(DAT_SEG2_MIN), .S2_MAX(DAT_SEG2_MAX), .J_MAX(DAT_SJW_MAX),
    .Q_MIN(DAT_Q_MIN), .Q_MAX(DAT_Q_MAX)
  ) u_dat_chk (
    .presc_i(dat_presc_i), .seg1_i(dat_seg1_i), .seg2_i(dat_seg2_i),
    .sjw_i(dat_sjw_i), .ok_o(dat_ok)
  );

  always_comb begin
    if (data_phase_i) begin
      sel_set.presc = NOM_PRESC_W'(dat_presc_i);
      sel_set.seg1  = NOM_SEG1_W'(dat_seg1_i);
      sel_set.seg2  = NOM_SEG2_W'(dat_seg2_i);
      sel_set.sjw   = NOM_SJW_W'(dat_sjw_i);
      err_d         = !dat_ok;
    end else begin
      sel_set.presc = nom_presc_i;
      sel_set.seg1  = nom_seg1_i;
      sel_set.seg2  = nom_seg2_i;
      sel_set.sjw   = nom_sjw_i;
      err_d         = !nom_ok;
    end
  end

  assign run  = !err_q;
  assign fall = rx_q && !rx_i;

  // active set follows the inputs while idle, otherwise only at bit end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= DEF_SET;
      err_q <= 1'b0;
      rx_q  <= 1'b1;
    end else begin
      err_q <= err_d;
      rx_q  <= rx_i;
      if (err_q || bit_end) act_q <= sel_set;
    end
  end

  can_bt_presc #(.W(NOM_PRESC_W)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .div_i(act_q.presc), .tick_o(tick)
  );

  can_bt_seg_fsm u_seg (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_i(tick), .edge_i(fall),
    .seg1_i(act_q.seg1), .seg2_i(act_q.seg2), .sjw_i(act_q.sjw),
    .sample_o(sample_o), .bit_end_o(bit_end)
  );

  assign tq_tick_o      = tick;
  assign bit_start_o    = bit_end;
  assign config_error_o = err_q;
endmodule

// File: rtl/can_bit_timing_chk.sv
module can_bit_timing_chk
  import can_bt_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    tq_tick_o,
  input logic    sample_o,
  input logic    bit_start_o,
  input logic    config_error_o,
  input bt_set_t act_q
);
  logic sample_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             sample_seen_q <= 1'b0;
    else if (config_error_o) sample_seen_q <= 1'b0;
    else if (sample_o)       sample_seen_q <= 1'b1;
    else if (bit_start_o)    sample_seen_q <= 1'b0;
  end

  AST_STROBE_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o || bit_start_o) |-> tq_tick_o); // R11
  AST_STROBES_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && bit_start_o)); // R11
  AST_IDLE_ON_ERROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    config_error_o |-> !(tq_tick_o || sample_o || bit_start_o)); // R6
  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tq_tick_o && !bit_start_o && act_q.presc > NOM_PRESC_W'(1)) |=> !tq_tick_o); // R2
  AST_SET_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_start_o && !config_error_o) |=> $stable(act_q)); // R7
  AST_SAMPLE_EACH_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_start_o |-> sample_seen_q); // R3
endmodule

bind can_bit_timing can_bit_timing_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tq_tick_o(tq_tick_o), .sample_o(sample_o),
  .bit_start_o(bit_start_o), .config_error_o(config_error_o), .act_q(act_q)
);

// File: tb/can_bit_timing_tb.sv
module can_bit_timing_tb;
  import can_bt_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic data_phase_i = 1'b0;
  logic [NOM_PRESC_W-1:0] nom_presc_i;
  logic [NOM_SEG1_W-1:0]  nom_seg1_i;
  logic [NOM_SEG2_W-1:0]  nom_seg2_i;
  logic [NOM_SJW_W-1:0]   nom_sjw_i;
  logic [DAT_PRESC_W-1:0] dat_presc_i;
  logic [DAT_SEG1_W-1:0]  dat_seg1_i;
  logic [DAT_SEG2_W-1:0]  dat_seg2_i;
  logic [DAT_SJW_W-1:0]   dat_sjw_i;
  logic rx_i = 1'b1;
  logic tq_tick_o, sample_o, bit_start_o, config_error_o;

  int n_vec = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  can_bit_timing u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .data_phase_i(data_phase_i),
    .nom_presc_i(nom_presc_i), .nom_seg1_i(nom_seg1_i), .nom_seg2_i(nom_seg2_i),
    .nom_sjw_i(nom_sjw_i), .dat_presc_i(dat_presc_i), .dat_seg1_i(dat_seg1_i),
    .dat_seg2_i(dat_seg2_i), .dat_sjw_i(dat_sjw_i), .rx_i(rx_i),
    .tq_tick_o(tq_tick_o), .sample_o(sample_o), .bit_start_o(bit_start_o),
    .config_error_o(config_error_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_nom(input int p, input int a, input int b, input int j);
    nom_presc_i = NOM_PRESC_W'(p);
    nom_seg1_i  = NOM_SEG1_W'(a);
    nom_seg2_i  = NOM_SEG2_W'(b);
    nom_sjw_i   = NOM_SJW_W'(j);
  endtask

  task automatic set_dat(input int p, input int a, input int b, input int j);
    dat_presc_i = DAT_PRESC_W'(p);
    dat_seg1_i  = DAT_SEG1_W'(a);
    dat_seg2_i  = DAT_SEG2_W'(b);
    dat_sjw_i   = DAT_SJW_W'(j);
  endtask

  task automatic wait_bit();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      if (bit_start_o) break;
    end
  endtask

  // counts negedges from the last boundary; e1/e2 drop rx_i at those indices
  task automatic run_bit(input int e1, input int e2, input int sw,
                         output int s_off, output int len, output int ticks);
    s_off = -1; len = -1; ticks = 0;
    for (int i = 1; i <= 4000; i++) begin
      @(negedge clk);
      if (i == e1) rx_i = 1'b0;
      if (e1 > 0 && i == e1 + 2) rx_i = 1'b1;
      if (i == e2) rx_i = 1'b0;
      if (i == sw) data_phase_i = 1'b1;
      #1;
      if (tq_tick_o) ticks++;
      if (sample_o && s_off < 0) s_off = i;
      if (bit_start_o) begin
        len = i;
        break;
      end
    end
    rx_i = 1'b1;
  endtask

  task automatic resync_case(input string tag, input int j, input int e1, input int e2,
                             input int exp_s, input int exp_len);
    int s, l, t;
    set_nom(1, 5, 4, j);
    wait_bit();
    wait_bit();
    run_bit(e1, e2, 0, s, l, t);
    chk({tag, " sample offset"}, s, exp_s);
    chk({tag, " bit length"}, l, exp_len);
  endtask

  task automatic err_case(input string tag, input logic sel,
                          input int np, input int na, input int nb, input int nj,
                          input int dp, input int da, input int db, input int dj,
                          input int exp_err);
    int t;
    set_nom(np, na, nb, nj);
    set_dat(dp, da, db, dj);
    data_phase_i = sel;
    @(negedge clk); @(negedge clk); #1;
    chk({tag, " config_error"}, int'(config_error_o), exp_err);
    if (exp_err != 0) begin
      t = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk); #1;
        if (tq_tick_o || sample_o || bit_start_o) t++;
      end
      chk({tag, " R6 idle strobes"}, t, 0);
    end
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    int s, l, t;
    set_nom(1, 5, 2, 1);
    set_dat(2, 3, 2, 1);
    repeat (3) @(negedge clk);
    #1;
    chk("R1 error in reset", int'(config_error_o), 0);
    chk("R1 strobes in reset", int'(sample_o || bit_start_o), 0);
    rst_ni = 1'b1;
    // first bit runs on reset defaults 1/11/4
    run_bit(0, 0, 0, s, l, t);
    chk("R1 first sample", s, 11);
    chk("R1 first boundary", l, 15);
    chk("R1 tick every cycle", t, 15);
    chk("R1 error after reset", int'(config_error_o), 0);
    run_bit(0, 0, 0, s, l, t);
    chk("R3 second bit sample", s, 6);
    chk("R3 second bit length", l, 8);

    // R2 R3 R4 nominal sweep
    for (int p = 1; p <= 3; p++)
      for (int a = 2; a <= 5; a++)
        for (int b = 2; b <= 4; b++) begin
          set_nom(p, a, b, 1);
          wait_bit();
          run_bit(0, 0, 0, s, l, t);
          chk("R3 nominal sample", s, p * (1 + a));
          chk("R3 nominal length", l, p * (1 + a + b));
          chk("R2 nominal ticks", t, 1 + a + b);
        end

    // R5 data sweep
    data_phase_i = 1'b1;
    for (int p = 1; p <= 2; p++)
      for (int a = 1; a <= 4; a++)
        for (int b = 1; b <= 3; b++) begin
          set_dat(p, a, b, 1);
          wait_bit();
          run_bit(0, 0, 0, s, l, t);
          chk("R5 data sample", s, p * (1 + a));
          chk("R5 data length", l, p * (1 + a + b));
          chk("R2 data ticks", t, 1 + a + b);
        end
    // R5 upper data limits are legal
    set_dat(32, 32, 16, 16);
    @(negedge clk); @(negedge clk); #1;
    chk("R5 max data legal", int'(config_error_o), 0);
    wait_bit();
    run_bit(0, 0, 0, s, l, t);
    chk("R5 max data sample", s, 32 * 33);
    chk("R5 max data length", l, 32 * 49);

    // R4 R5 R6 range checks
    err_case("R4 nom max legal",   1'b0, 512, 256, 128, 128, 2, 3, 2, 1, 0);
    err_case("R4 nom sjw 0",       1'b0, 1, 5, 4, 0,   2, 3, 2, 1, 1);
    err_case("R4 nom sjw 129",     1'b0, 1, 5, 4, 129, 2, 3, 2, 1, 1);
    err_case("R4 nom seg1 1",      1'b0, 1, 1, 4, 1,   2, 3, 2, 1, 1);
    err_case("R4 nom seg1 257",    1'b0, 1, 257, 4, 1, 2, 3, 2, 1, 1);
    err_case("R4 nom seg2 1",      1'b0, 1, 5, 1, 1,   2, 3, 2, 1, 1);
    err_case("R4 nom seg2 129",    1'b0, 1, 5, 129, 1, 2, 3, 2, 1, 1);
    err_case("R4 nom presc 0",     1'b0, 0, 5, 4, 1,   2, 3, 2, 1, 1);
    err_case("R4 nom presc 513",   1'b0, 513, 5, 4, 1, 2, 3, 2, 1, 1);
    err_case("R4 data ignored",    1'b0, 1, 5, 4, 2,   33, 0, 0, 0, 0);
    err_case("R5 dat presc 33",    1'b1, 1, 5, 4, 2,   33, 3, 2, 1, 1);
    err_case("R5 dat seg1 0",      1'b1, 1, 5, 4, 2,   2, 0, 2, 1, 1);
    err_case("R5 dat seg1 33",     1'b1, 1, 5, 4, 2,   2, 33, 2, 1, 1);
    err_case("R5 dat seg2 0",      1'b1, 1, 5, 4, 2,   2, 3, 0, 1, 1);
    err_case("R5 dat seg2 17",     1'b1, 1, 5, 4, 2,   2, 3, 17, 1, 1);
    err_case("R5 dat sjw 17",      1'b1, 1, 5, 4, 2,   2, 3, 2, 17, 1);
    err_case("R5 nominal ignored", 1'b1, 0, 0, 0, 0,   2, 3, 2, 1, 0);
    err_case("R6 before recovery", 1'b0, 0, 0, 0, 0,   2, 3, 2, 1, 1);

    // R6 recovery
    set_nom(1, 5, 4, 2);
    data_phase_i = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    chk("R6 error cleared", int'(config_error_o), 0);
    wait_bit();
    run_bit(0, 0, 0, s, l, t);
    chk("R6 restart length", l, 10);

    // R7 switch mid-bit: current bit keeps nominal timing
    set_dat(2, 3, 2, 1);
    wait_bit();
    run_bit(0, 0, 3, s, l, t);
    chk("R7 bit in progress", l, 10);
    run_bit(0, 0, 0, s, l, t);
    chk("R7 data sample", s, 8);
    chk("R7 data length", l, 12);
    data_phase_i = 1'b0;
    wait_bit();

    // R8 R9 R10 resync, nominal 1/5/4
    resync_case("R8 early seg1 sjw2", 2, 3, 0, 8, 12);
    resync_case("R8 early seg1 sjw1", 1, 3, 0, 7, 11);
    resync_case("R8 last seg1 quantum", 2, 6, 0, 8, 12);
    resync_case("R9 seg2 sjw2", 2, 8, 0, 6, 8);
    resync_case("R9 seg2 sjw1", 1, 8, 0, 6, 9);
    resync_case("R9 last seg2 quantum", 2, 10, 0, 6, 10);
    resync_case("R10 edge in sync", 2, 1, 0, 6, 10);
    resync_case("R10 second edge", 2, 3, 10, 8, 12);
    resync_case("R10 no edge", 2, 0, 0, 6, 10);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule